// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns internal memory requests into cycles on an external memory bus. A requester presents a 24-bit internal address, write data, a direction bit and two byte-lane enables, and raises `req_i`. The block latches the request, runs one or two four-clock bus cycles, and pulses `ready_o` in the final clock. For reads, the collected data is on `rdata_o` during that clock.

The shape of the bus is chosen per request by `mode_i`. The data path is either 8 or 16 bits wide, and addresses either share the address/data pins with data (multiplexed) or use only the separate address lines (demultiplexed). The mode decides, for each phase of the cycle, what each address/data pin carries: low or high address bits, a data byte, or nothing at all. On an 8-bit bus, a two-lane request becomes two byte cycles.

Between cycles, the shared pins return to general-purpose port values. These are supplied on `port_ad_i` and `port_ahi_i`.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, the block is idle. `addr_o` reads 16'h2080, the low half of the reset fetch address 1F2080h. `ale_o` is low, `rd_n_o`, `wr_n_o` and `ad_oe_o` are all high, `ready_o` is low, `rdata_o` is zero, and `ad_o` follows `port_ad_i`.
- R2: Each byte or word cycle takes four clocks: address-latch, address-hold, strobe and recovery. `ale_o` is high only in the first clock. `rd_n_o` (reads) or `wr_n_o` (writes) is low only in the third clock. `ready_o` is high only in the recovery clock of the last cycle, so a single-cycle request completes four clocks after it is accepted.
- R3: Throughout a cycle, `addr_hi_o` and `addr_o` together present the 21-bit external address. Internal address bits 23:21 are dropped.
- R4: When `mode_i` = 2'b01 (bit 0 set means 16-bit, bit 1 clear means multiplexed), `ad_o` carries address bits 15:0 in the first two clocks. It then carries write data, or is released for read data, in the last two clocks.
- R5: When `mode_i` = 2'b00 (8-bit multiplexed), `ad_o[15:8]` carries address bits 15:8 and is enabled for the whole cycle. `ad_o[7:0]` carries address bits 7:0 in the first two clocks and the data byte in the last two.
- R6: When `mode_i` = 2'b11 (16-bit demultiplexed), `ad_o` carries only data (write data, or released for a read) for the whole cycle.
- R7: When `mode_i` = 2'b10 (8-bit demultiplexed), `ad_o[7:0]` carries the data byte for the whole cycle. `ad_o[15:8]` always drives the high byte of the latched write word.
- R8: In 8-bit modes with `be_i` = 2'b11, two byte cycles run. The low byte goes first at the even address, then the high byte at the odd address, and both travel on `ad_o[7:0]`. `ready_o` stays low after the first byte cycle.
- R9: On reads, every lane that carries data has its `ad_oe_o` bit low (bit 0 for `ad_o[7:0]`, bit 1 for `ad_o[15:8]`). The lane is sampled on the last strobe clock into the `rdata_o` lane it belongs to. `rdata_o` is cleared when a request is accepted, so lanes that are not enabled (and all lanes on writes) read zero.
- R10: While idle, `ad_o` equals `port_ad_i` with both `ad_oe_o` bits high, and `addr_hi_o` equals `port_ahi_i`.
- R11: In 16-bit modes, a single-byte request is one cycle. `be_i` = 2'b01 gives an even address and `be_i` = 2'b10 gives an odd address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bus mode: bit 0 = 16-bit width, bit 1 = demultiplexed |
| req_i | input | 1 | Request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte-lane enables (bit 0 = low byte) |
| addr_i | input | 24 | Internal byte address |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Request completion pulse |
| rdata_o | output | 16 | Read data, valid with ready_o |
| port_ad_i | input | 16 | Port values for the address/data pins when idle |
| port_ahi_i | input | 5 | Port values for the upper address pins when idle |
| ad_i | input | 16 | Address/data pin input |
| ad_o | output | 16 | Address/data pin output |
| ad_oe_o | output | 2 | Per-byte output enable of the address/data pins |
| addr_o | output | 16 | Address bits 15:0 |
| addr_hi_o | output | 5 | Address bits 20:16, or port values when idle |
| ale_o | output | 1 | Address latch enable, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The bench targets the pin swap between the address phase and the data phase in every mode. If the swap happened one clock off, data would appear alongside `ale_o`, or the address would still be on the pins under the strobe. It drives split word transfers on the 8-bit bus. A wrong design there would reverse the byte order, keep the even address for the second byte, or signal completion after the first byte. It also issues reads that must leave the pins released under the strobe and land each byte in the correct `rdata_o` lane, and it checks that the port values return in the idle clock and that the upper address bits never leak out.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALE  = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_REC  = 3'd4
  } phase_e;

  typedef struct packed {
    logic demux;
    logic wide;
  } mode_t;
endpackage

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int EAW = 21,
  parameter int DW  = 16,
  parameter logic [EAW-1:0] RST_ADDR = 21'h1F2080,
  localparam int NB = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [NB-1:0]  be_i,
  input  mode_t          mode_i,
  input  logic [EAW-1:1] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output phase_e         phase_o,
  output mode_t          mode_o,
  output logic           we_o,
  output logic [NB-1:0]  be_o,
  output logic [EAW-1:0] addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           byte_sel_o,
  output logic           start_o,
  output logic           ready_o
);
  logic pend_q;
  logic hi_only;

  assign hi_only = (be_i == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o    <= PH_IDLE;
      mode_o     <= '0;
      we_o       <= 1'b0;
      be_o       <= '0;
      addr_o     <= RST_ADDR;
      wdata_o    <= '0;
      byte_sel_o <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      unique case (phase_o)
        PH_IDLE: if (req_i) begin
          phase_o <= PH_ALE;
          mode_o  <= mode_i;
          we_o    <= we_i;
          be_o    <= be_i;
          wdata_o <= wdata_i;
          if (mode_i.wide) begin
            addr_o     <= {addr_i, hi_only};
            byte_sel_o <= hi_only;
            pend_q     <= 1'b0;
          end else begin
            // byte lane order: low first, high at addr+1
            addr_o     <= {addr_i, ~be_i[0]};
            byte_sel_o <= ~be_i[0];
            pend_q     <= &be_i;
          end
        end
        PH_ALE:  phase_o <= PH_HOLD;
        PH_HOLD: phase_o <= PH_STRB;
        PH_STRB: phase_o <= PH_REC;
        PH_REC: begin
          if (pend_q) begin
            pend_q     <= 1'b0;
            byte_sel_o <= 1'b1;
            addr_o[0]  <= 1'b1;
            phase_o    <= PH_ALE;
          end else begin
            phase_o <= PH_IDLE;
          end
        end
        default: phase_o <= PH_IDLE;
      endcase
    end
  end

  assign start_o = (phase_o == PH_IDLE) && req_i;
  assign ready_o = (phase_o == PH_REC) && !pend_q;
endmodule

// File: rtl/ext_bus_pinmux.sv
module ext_bus_pinmux
  import ext_bus_pkg::*;
#(
  parameter int EAW = 21,
  parameter int DW  = 16,
  localparam int NB  = DW / 8,
  localparam int HB  = DW / 2,
  localparam int HIW = EAW - DW
) (
  input  phase_e         phase_i,
  input  mode_t          mode_i,
  input  logic           we_i,
  input  logic           byte_sel_i,
  input  logic [EAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [DW-1:0]  port_ad_i,
  input  logic [HIW-1:0] port_ahi_i,
  output logic [DW-1:0]  ad_o,
  output logic [NB-1:0]  ad_oe_o,
  output logic [DW-1:0]  addr_o,
  output logic [HIW-1:0] addr_hi_o,
  output logic           ale_o,
  output logic           rd_n_o,
  output logic           wr_n_o
);
  logic          active;
  logic          aph;
  logic [HB-1:0] byte_d;

  assign active = (phase_i != PH_IDLE);
  assign aph    = (phase_i == PH_ALE) || (phase_i == PH_HOLD);
  assign byte_d = byte_sel_i ? wdata_i[DW-1:HB] : wdata_i[HB-1:0];

  always_comb begin
    ad_o      = port_ad_i;
    ad_oe_o   = '1;
    addr_hi_o = port_ahi_i;
    if (active) begin
      addr_hi_o = addr_i[EAW-1:DW];
      unique case ({mode_i.demux, mode_i.wide})
        2'b01: begin
          if (aph) begin
            ad_o    = addr_i[DW-1:0];
            ad_oe_o = '1;
          end else begin
            ad_o    = wdata_i;
            ad_oe_o = {NB{we_i}};
          end
        end
        2'b00: begin
          ad_o[DW-1:HB] = addr_i[DW-1:HB];
          ad_oe_o[1]    = 1'b1;
          if (aph) begin
            ad_o[HB-1:0] = addr_i[HB-1:0];
            ad_oe_o[0]   = 1'b1;
          end else begin
            ad_o[HB-1:0] = byte_d;
            ad_oe_o[0]   = we_i;
          end
        end
        2'b11: begin
          ad_o    = wdata_i;
          ad_oe_o = {NB{we_i}};
        end
        default: begin
          // high byte mirrors the internal word's upper half
          ad_o[DW-1:HB] = wdata_i[DW-1:HB];
          ad_oe_o[1]    = 1'b1;
          ad_o[HB-1:0]  = byte_d;
          ad_oe_o[0]    = we_i;
        end
      endcase
    end
  end

  assign addr_o = addr_i[DW-1:0];
  assign ale_o  = (phase_i == PH_ALE);
  assign rd_n_o = !((phase_i == PH_STRB) && !we_i);
  assign wr_n_o = !((phase_i == PH_STRB) && we_i);
endmodule

// File: rtl/ext_bus_rdcap.sv
module ext_bus_rdcap
  import ext_bus_pkg::*;
#(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          wide_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic          byte_sel_i,
  input  logic          start_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o
);
  logic cap;

  assign cap = (phase_i == PH_STRB) && !we_i;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_o[l*8 +: 8] <= '0;
      end else if (start_i) begin
        rdata_o[l*8 +: 8] <= '0;
      end else if (cap) begin
        if (wide_i) begin
          if (be_i[l]) rdata_o[l*8 +: 8] <= ad_i[l*8 +: 8];
        end else if (byte_sel_i == 1'(l)) begin
          rdata_o[l*8 +: 8] <= ad_i[7:0];
        end
      end
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ext_bus_pkg::*;
#(
  parameter int AW  = 24,
  parameter int EAW = 21,
  parameter int DW  = 16,
  parameter logic [AW-1:0] RESET_ADDR = 24'h1F2080,
  localparam int NB  = DW / 8,
  localparam int HIW = EAW - DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [NB-1:0]  be_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           ready_o,
  output logic [DW-1:0]  rdata_o,
  input  logic [DW-1:0]  port_ad_i,
  input  logic [HIW-1:0] port_ahi_i,
  input  logic [DW-1:0]  ad_i,
  output logic [DW-1:0]  ad_o,
  output logic [NB-1:0]  ad_oe_o,
  output logic [DW-1:0]  addr_o,
  output logic [HIW-1:0] addr_hi_o,
  output logic           ale_o,
  output logic           rd_n_o,
  output logic           wr_n_o
);
  phase_e         phase;
  mode_t          mode_q;
  logic           we_q;
  logic [NB-1:0]  be_q;
  logic [EAW-1:0] cur_addr;
  logic [DW-1:0]  wdata_q;
  logic           byte_sel;
  logic           start;

  ext_bus_seq #(.EAW(EAW), .DW(DW), .RST_ADDR(RESET_ADDR[EAW-1:0])) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .be_i       (be_i),
    .mode_i     (mode_t'(mode_i)),
    .addr_i     (addr_i[EAW-1:1]),
    .wdata_i    (wdata_i),
    .phase_o    (phase),
    .mode_o     (mode_q),
    .we_o       (we_q),
    .be_o       (be_q),
    .addr_o     (cur_addr),
    .wdata_o    (wdata_q),
    .byte_sel_o (byte_sel),
    .start_o    (start),
    .ready_o    (ready_o)
  );

  ext_bus_pinmux #(.EAW(EAW), .DW(DW)) u_pinmux (
    .phase_i    (phase),
    .mode_i     (mode_q),
    .we_i       (we_q),
    .byte_sel_i (byte_sel),
    .addr_i     (cur_addr),
    .wdata_i    (wdata_q),
    .port_ad_i  (port_ad_i),
    .port_ahi_i (port_ahi_i),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .addr_o     (addr_o),
    .addr_hi_o  (addr_hi_o),
    .ale_o      (ale_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o)
  );

  ext_bus_rdcap #(.DW(DW)) u_rdcap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .wide_i     (mode_q.wide),
    .we_i       (we_q),
    .be_i       (be_q),
    .byte_sel_i (byte_sel),
    .start_i    (start),
    .ad_i       (ad_i),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/ext_bus_chk.sv
module ext_bus_chk #(
  parameter int AW  = 24,
  parameter int EAW = 21,
  parameter int DW  = 16,
  localparam int NB  = DW / 8,
  localparam int HIW = EAW - DW,
  localparam logic [AW-1:0] AMASK = {{(AW-EAW){1'b0}}, {(EAW-1){1'b1}}, 1'b0}
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [AW-1:0]  addr_i,
  input logic           ale_o,
  input logic           rd_n_o,
  input logic           wr_n_o,
  input logic           ready_o,
  input logic [NB-1:0]  ad_oe_o,
  input logic [DW-1:0]  addr_o,
  input logic [HIW-1:0] addr_hi_o
);
  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  // R2
  strobe_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> $past(ale_o, 2));

  // R2
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rd_n_o && wr_n_o && !ale_o));

  // R9
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o[0]);

  // R3
  addr_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ale_o && ({{(AW-EAW){1'b0}}, addr_hi_o, addr_o[DW-1:1], 1'b0}
                            == ($past(addr_i) & AMASK))));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> ($stable(addr_o) && $stable(addr_hi_o)));
endmodule

bind ext_bus_ctrl ext_bus_chk #(.AW(AW), .EAW(EAW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start),
  .addr_i    (addr_i),
  .ale_o     (ale_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .ready_o   (ready_o),
  .ad_oe_o   (ad_oe_o),
  .addr_o    (addr_o),
  .addr_hi_o (addr_hi_o)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  be_i = 2'b11;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ready_o;
  logic [15:0] rdata_o;
  logic [15:0] port_ad_i = 16'h3C5A;
  logic [4:0]  port_ahi_i = 5'h15;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic [1:0]  ad_oe_o;
  logic [15:0] addr_o;
  logic [4:0]  addr_hi_o;
  logic        ale_o, rd_n_o, wr_n_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ext_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i), .we_i(we_i),
    .be_i(be_i), .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o),
    .rdata_o(rdata_o), .port_ad_i(port_ad_i), .port_ahi_i(port_ahi_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .addr_o(addr_o),
    .addr_hi_o(addr_hi_o), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R4";
      2'b00:   return "R5";
      2'b11:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // {oe[1:0], ad[15:0]} expected from the mode requirements
  function automatic logic [17:0] exp_pins(input logic [1:0] m, input logic w,
      input logic sel, input logic [15:0] a, input logic [15:0] d, input int ph);
    logic       aph = (ph < 2);
    logic [7:0] bd  = sel ? d[15:8] : d[7:0];
    case (m)
      2'b01:   return aph ? {2'b11, a} : {w, w, d};
      2'b00:   return {1'b1, (aph ? 1'b1 : w), a[15:8], (aph ? a[7:0] : bd)};
      2'b11:   return {w, w, d};
      default: return {1'b1, w, d[15:8], bd};
    endcase
  endfunction

  task automatic check_idle(input string tag);
    chk(tag, "idle ad", {16'h0, ad_o}, {16'h0, port_ad_i});
    chk(tag, "idle oe", {30'h0, ad_oe_o}, 32'h3);
    chk(tag, "idle ahi", {27'h0, addr_hi_o}, {27'h0, port_ahi_i});
    chk(tag, "idle ctl", {28'h0, ale_o, rd_n_o, wr_n_o, ready_o}, 32'h6);
  endtask

  task automatic run(input logic [1:0] m, input logic w, input logic [1:0] be,
                     input logic [23:0] a, input logic [15:0] d);
    logic [20:0] cadr [2];
    logic        csel [2];
    logic [15:0] rv   [2];
    logic [15:0] exp_rd;
    logic [17:0] ep;
    logic [15:0] mask;
    int          n;
    string       atag, ptag;
    rv[0] = 16'($urandom);
    rv[1] = 16'($urandom);
    if (m[0]) begin
      n = 1;
      csel[0] = (be == 2'b10);
      cadr[0] = {a[20:1], csel[0]};
      exp_rd  = {be[1] ? rv[0][15:8] : 8'h00, be[0] ? rv[0][7:0] : 8'h00};
      atag    = (be == 2'b11) ? "R3" : "R11";
    end else begin
      exp_rd = '0;
      if (be == 2'b11) begin
        n = 2;
        csel[0] = 1'b0; cadr[0] = {a[20:1], 1'b0};
        csel[1] = 1'b1; cadr[1] = {a[20:1], 1'b1};
        exp_rd  = {rv[1][7:0], rv[0][7:0]};
        atag    = "R8";
      end else begin
        n = 1;
        csel[0] = (be == 2'b10);
        cadr[0] = {a[20:1], csel[0]};
        if (csel[0]) exp_rd[15:8] = rv[0][7:0];
        else         exp_rd[7:0]  = rv[0][7:0];
        atag    = "R3";
      end
    end
    if (w) exp_rd = '0;

    @(negedge clk);
    mode_i = m; we_i = w; be_i = be; addr_i = a; wdata_i = d; req_i = 1'b1;
    for (int c = 0; c < n; c++) begin
      for (int ph = 0; ph < 4; ph++) begin
        logic last;
        @(negedge clk);
        if (ph == 0) ad_i = rv[c];
        last = (c == n - 1) && (ph == 3);
        chk("R2", "ale", {31'h0, ale_o}, {31'h0, (ph == 0)});
        chk("R2", "rd_n", {31'h0, rd_n_o}, {31'h0, !(ph == 2 && !w)});
        chk("R2", "wr_n", {31'h0, wr_n_o}, {31'h0, !(ph == 2 && w)});
        chk(atag, "addr", {11'h0, addr_hi_o, addr_o}, {11'h0, cadr[c]});
        ep   = exp_pins(m, w, csel[c], cadr[c][15:0], d, ph);
        mask = {{8{ep[17]}}, {8{ep[16]}}};
        ptag = (!w && ph >= 2) ? "R9" : mode_tag(m);
        if (n == 2 && ph >= 2) ptag = "R8";
        chk(ptag, "oe", {30'h0, ad_oe_o}, {30'h0, ep[17:16]});
        chk(ptag, "ad", {16'h0, ad_o & mask}, {16'h0, ep[15:0] & mask});
        chk(last ? "R2" : "R8", "ready", {31'h0, ready_o}, {31'h0, last});
        if (last) begin
          chk("R9", "rdata", {16'h0, rdata_o}, {16'h0, exp_rd});
          req_i = 1'b0;
        end
      end
    end
    @(negedge clk);
    check_idle("R10");
    port_ad_i  = 16'($urandom);
    port_ahi_i = 5'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "addr", {16'h0, addr_o}, 32'h2080);
    chk("R1", "rdata", {16'h0, rdata_o}, 32'h0);
    check_idle("R1");

    // directed: every mode, word and byte, read and write, high internal bits set
    for (int m = 0; m < 4; m++) begin
      run(2'(m), 1'b1, 2'b11, 24'hE5A5A4, 16'hBEEF);
      run(2'(m), 1'b0, 2'b11, 24'hE5A5A4, 16'h1234);
      run(2'(m), 1'b1, 2'b01, 24'hA01236, 16'hC3D2);
      run(2'(m), 1'b0, 2'b10, 24'h3FFFFE, 16'h0F0F);
      run(2'(m), 1'b0, 2'b01, 24'h000000, 16'hFFFF);
    end
    // random mix
    for (int i = 0; i < 60; i++) begin
      int b = int'($urandom % 3);
      run(2'($urandom), 1'($urandom), (b == 0) ? 2'b01 : (b == 1) ? 2'b10 : 2'b11,
          24'($urandom), 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule